// File: doc/BRIEF.md
# Event-to-Counter Binding Table

This block keeps a small associative table that tells a performance-monitoring unit which programmable counter should count a given hardware event. Software programs a counter by writing its event selector. Each selector write passes through this block, which keeps, removes or ignores a binding depending on the counter index and the selector value. When an event fires, the event code is presented on the lookup port. The block returns at once whether a counter is bound to that event and, if so, which one. The caller drops an event that misses.

The table has one slot for each supported event code. Five codes are supported, so there are five slots. An event keeps the first counter it was bound to until that counter's selector is written with zero. That zero write removes every binding that points at the counter, and a single counter may hold several bindings. With a 32-bit register file the selector is written in two halves. The low half is only stored. The binding is evaluated when the high half arrives, using the high word on top of the stored low word.

Top module: `evtmap_table`

## Requirements
- R1: After a synchronous reset every slot is empty, so a lookup of any code returns lookup_hit=0 and lookup_ctr=0.
- R2: A write whose counter index is below 3 or at or above 3+NUM_CTRS (default NUM_CTRS=16, so index 19 and up) leaves the table unchanged; index 18 is accepted.
- R3: In 64-bit mode (mode32=0) a low-half write (wr_hi=0) with a non-zero selector binds the event code in selector bits [19:0] to wr_idx; selector bits 63:20 play no part beyond making the value non-zero.
- R4: A write naming an event code that is already bound leaves that binding and every other slot unchanged.
- R5: A write whose selector value is zero removes every binding whose counter equals wr_idx, and no others; if no binding points at wr_idx nothing changes.
- R6: Only the codes 0x00001, 0x00002, 0x10019, 0x1001B and 0x10021 are bound; a non-zero selector that carries any other code, including code 0, changes nothing.
- R7: In 32-bit mode (mode32=1) a low-half write (wr_hi=0) changes no binding and stores wr_sel[31:0] as the counter's low word. A high-half write (wr_hi=1) evaluates the 64-bit value {wr_sel[31:0], stored low word} under R3 to R6, so a zero low word with a non-zero high word is not a removal.
- R8: In 64-bit mode a high-half write (wr_hi=1) changes no binding.
- R9: The lookup is combinational on the table: lookup_hit=1 with the bound counter on lookup_ctr when lookup_evt is bound, otherwise lookup_hit=0 and lookup_ctr=0. A write is visible to lookups from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Selector write strobe |
| wr_idx | input | 5 | Counter index being written |
| wr_sel | input | 64 | Selector value (the low 32 bits are used in 32-bit mode) |
| mode32 | input | 1 | 1: selectors are written as two 32-bit halves |
| wr_hi | input | 1 | 1: this write targets the high half of the selector |
| lookup_evt | input | 20 | Event code to look up |
| lookup_hit | output | 1 | A counter is bound to lookup_evt |
| lookup_ctr | output | 5 | Counter bound to lookup_evt, zero on a miss |

## Verification
The assertions assume that wr_idx, wr_sel, mode32 and wr_hi are stable across the clock edge whenever wr_valid is high. They also assume that mode32 is not toggled between the two halves of a 32-bit write, because the stored low word is then read back under the other interpretation. The stimulus changes every input only on the falling edge. It keeps mode32 constant through each pair of half writes, and it issues writes only through a task that also updates the reference model on the same rising edge. The sequence reaches the index boundaries 2, 3, 18 and 19, and it places two bindings on one counter so that a single removal has to clear both.

// File: rtl/evtmap_pkg.sv
package evtmap_pkg;

    localparam int MAX_CTRS = 32;
    localparam int CTR_W    = $clog2(MAX_CTRS);
    localparam int FIRST_PROG = 3;
    localparam int EVT_W    = 20;
    localparam int SEL_W    = 64;
    localparam int HALF_W   = 32;
    localparam int NUM_EVT  = 5;

    typedef logic [CTR_W-1:0] ctr_t;
    typedef logic [EVT_W-1:0] evt_t;

    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_BIND  = 2'd2
    } upd_kind_e;

    typedef struct packed {
        upd_kind_e            kind;
        logic [NUM_EVT-1:0]   slot_oh;
        ctr_t                 ctr;
    } upd_t;

    function automatic evt_t slot_code(input int s);
        case (s)
            0:       slot_code = 20'h00001;
            1:       slot_code = 20'h00002;
            2:       slot_code = 20'h10019;
            3:       slot_code = 20'h1001B;
            default: slot_code = 20'h10021;
        endcase
    endfunction

    function automatic logic [NUM_EVT-1:0] code_onehot(input evt_t code);
        logic [NUM_EVT-1:0] oh;
        for (int s = 0; s < NUM_EVT; s++) begin
            oh[s] = (code == slot_code(s));
        end
        return oh;
    endfunction

    function automatic logic ctr_eligible(input ctr_t idx, input int n_ctrs);
        int unsigned top;
        top = FIRST_PROG + n_ctrs;
        if (top > MAX_CTRS) top = MAX_CTRS;
        return (int'(idx) >= FIRST_PROG) && (int'(idx) < int'(top));
    endfunction

endpackage

// File: rtl/evtmap_wr_decode.sv
module evtmap_wr_decode
    import evtmap_pkg::*;
#(
    parameter int NUM_CTRS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  ctr_t              wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              mode32,
    input  logic              wr_hi,
    output upd_t              upd
);

    logic [HALF_W-1:0] low_q [MAX_CTRS];
    logic              elig;
    logic              store_low;
    logic              act;
    logic [SEL_W-1:0]  sel_eff;
    evt_t              code;
    logic [NUM_EVT-1:0] oh;

    assign elig      = ctr_eligible(wr_idx, NUM_CTRS);
    assign store_low = wr_valid && elig && !wr_hi;
    assign act       = wr_valid && elig && (mode32 ? wr_hi : !wr_hi);
    assign sel_eff   = mode32 ? {wr_sel[HALF_W-1:0], low_q[wr_idx]} : wr_sel;
    assign code      = sel_eff[EVT_W-1:0];
    assign oh        = code_onehot(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_CTRS; i++) begin
                low_q[i] <= '0;
            end
        end else if (store_low) begin
            low_q[wr_idx] <= wr_sel[HALF_W-1:0];
        end
    end

    always_comb begin
        upd.kind    = UPD_NONE;
        upd.slot_oh = '0;
        upd.ctr     = wr_idx;
        if (act) begin
            if (sel_eff == '0) begin
                upd.kind = UPD_CLEAR;
            end else if (|oh) begin
                upd.kind    = UPD_BIND;
                upd.slot_oh = oh;
            end
        end
    end

    AST_UPD_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        (upd.kind != UPD_NONE) |-> ctr_eligible(wr_idx, NUM_CTRS)); // R2

    AST_UPD_BIND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (upd.kind == UPD_BIND) |-> $onehot0(upd.slot_oh) && (upd.slot_oh != '0)); // R6

endmodule

// File: rtl/evtmap_slot.sv
module evtmap_slot
    import evtmap_pkg::*;
#(
    parameter int SLOT     = 0,
    parameter int NUM_CTRS = 16
) (
    input  logic clk,
    input  logic rst,
    input  upd_t upd,
    output logic valid,
    output ctr_t ctr
);

    logic hit_clear;
    logic take_bind;

    assign hit_clear = (upd.kind == UPD_CLEAR) && valid && (ctr == upd.ctr);
    assign take_bind = (upd.kind == UPD_BIND) && upd.slot_oh[SLOT] && !valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            ctr   <= '0;
        end else if (hit_clear) begin
            valid <= 1'b0;
            ctr   <= '0;
        end else if (take_bind) begin
            valid <= 1'b1;
            ctr   <= upd.ctr;
        end
    end

    AST_FIRST_BIND_KEPT: assert property (@(posedge clk) disable iff (rst)
        (valid && upd.kind == UPD_BIND) |=> (valid && $stable(ctr))); // R4

    AST_ZERO_WRITE_REMOVES: assert property (@(posedge clk) disable iff (rst)
        (valid && upd.kind == UPD_CLEAR && upd.ctr == ctr) |=> !valid); // R5

    AST_BOUND_CTR_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        valid |-> ctr_eligible(ctr, NUM_CTRS)); // R2

endmodule

// File: rtl/evtmap_lookup.sv
module evtmap_lookup
    import evtmap_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_EVT-1:0]            slot_valid,
    input  logic [NUM_EVT-1:0][CTR_W-1:0] slot_ctr,
    input  evt_t                          evt,
    output logic                          hit,
    output ctr_t                          ctr
);

    logic [NUM_EVT-1:0] match;

    always_comb begin
        ctr = '0;
        for (int s = 0; s < NUM_EVT; s++) begin
            match[s] = slot_valid[s] && (evt == slot_code(s));
            if (match[s]) ctr = ctr | slot_ctr[s];
        end
    end

    assign hit = |match;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R9

    AST_MISS_ZERO_CTR: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (ctr == '0)); // R9

endmodule

// File: rtl/evtmap_table.sv
module evtmap_table
    import evtmap_pkg::*;
#(
    parameter int NUM_CTRS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [4:0]  wr_idx,
    input  logic [63:0] wr_sel,
    input  logic        mode32,
    input  logic        wr_hi,
    input  logic [19:0] lookup_evt,
    output logic        lookup_hit,
    output logic [4:0]  lookup_ctr
);

    upd_t                          upd;
    logic [NUM_EVT-1:0]            slot_valid;
    logic [NUM_EVT-1:0][CTR_W-1:0] slot_ctr;
    logic                          idx_ok;

    assign idx_ok = ctr_eligible(wr_idx, NUM_CTRS);

    evtmap_wr_decode #(.NUM_CTRS(NUM_CTRS)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_idx   (wr_idx),
        .wr_sel   (wr_sel),
        .mode32   (mode32),
        .wr_hi    (wr_hi),
        .upd      (upd)
    );

    for (genvar s = 0; s < NUM_EVT; s++) begin : g_slot
        evtmap_slot #(.SLOT(s), .NUM_CTRS(NUM_CTRS)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .upd   (upd),
            .valid (slot_valid[s]),
            .ctr   (slot_ctr[s])
        );
    end

    evtmap_lookup u_lkp (
        .clk        (clk),
        .rst        (rst),
        .slot_valid (slot_valid),
        .slot_ctr   (slot_ctr),
        .evt        (lookup_evt),
        .hit        (lookup_hit),
        .ctr        (lookup_ctr)
    );

    AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !idx_ok) |=> ($stable(slot_valid) && $stable(slot_ctr))); // R2

    AST_LOW_HALF_NO_BIND: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && mode32 && !wr_hi) |=> ($stable(slot_valid) && $stable(slot_ctr))); // R7

    AST_HIGH64_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !mode32 && wr_hi) |=> ($stable(slot_valid) && $stable(slot_ctr))); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> ($stable(slot_valid) && $stable(slot_ctr))); // R9

endmodule

// File: tb/evtmap_table_bench.sv
`timescale 1ns/1ps
module evtmap_table_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [4:0]  wr_idx;
    logic [63:0] wr_sel;
    logic        mode32;
    logic        wr_hi;
    logic [19:0] lookup_evt;
    logic        lookup_hit;
    logic [4:0]  lookup_ctr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int unsigned emap [int unsigned];
    logic [31:0] lowq [int unsigned];

    always #2 clk = ~clk;

    evtmap_table #(.NUM_CTRS(N)) u_evtmap_table (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .mode32(mode32), .wr_hi(wr_hi),
        .lookup_evt(lookup_evt), .lookup_hit(lookup_hit), .lookup_ctr(lookup_ctr)
    );

    function automatic bit listed(int unsigned c);
        return c == 32'h1 || c == 32'h2 || c == 32'h10019 || c == 32'h1001B || c == 32'h10021;
    endfunction

    task automatic model_apply(int unsigned idx, logic [63:0] v);
        int unsigned keys[$];
        int unsigned c;
        if (v == 64'd0) begin
            foreach (emap[k]) if (emap[k] == idx) keys.push_back(k);
            foreach (keys[i]) emap.delete(keys[i]);
        end else begin
            c = int'(v[19:0]);
            if (!emap.exists(c) && listed(c)) emap[c] = idx;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            emap.delete();
            lowq.delete();
        end else if (wr_valid && wr_idx >= 3 && wr_idx < 3 + N) begin
            if (!wr_hi) lowq[wr_idx] = wr_sel[31:0];
            if (mode32 && wr_hi)
                model_apply(wr_idx, {wr_sel[31:0], (lowq.exists(wr_idx) ? lowq[wr_idx] : 32'd0)});
            else if (!mode32 && !wr_hi)
                model_apply(wr_idx, wr_sel);
        end
    end

    task automatic compare(string req);
        bit          eh;
        logic [4:0]  ec;
        eh = emap.exists(lookup_evt);
        ec = eh ? 5'(emap[lookup_evt]) : 5'd0;
        n_cmp++;
        if (lookup_hit !== eh || lookup_ctr !== ec) begin
            n_bad++;
            $display("FAIL %s evt=%h actual hit=%0b ctr=%0d expected hit=%0b ctr=%0d",
                     req, lookup_evt, lookup_hit, lookup_ctr, eh, ec);
        end
    endtask

    task automatic cyc(string req, bit wv, int idx, logic [63:0] sel, bit m32, bit hi, logic [19:0] evt);
        @(negedge clk);
        wr_valid   = wv;
        wr_idx     = 5'(idx);
        wr_sel     = sel;
        mode32     = m32;
        wr_hi      = hi;
        lookup_evt = evt;
        #1;
        compare(req);
    endtask

    task automatic look(string req, logic [19:0] evt);
        cyc(req, 0, 0, 64'd0, 0, 0, evt);
    endtask

    initial begin
        rst = 1'b1; wr_valid = 0; wr_idx = 0; wr_sel = 0; mode32 = 0; wr_hi = 0; lookup_evt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: empty after reset
        look("R1", 20'h00001); look("R1", 20'h00002); look("R1", 20'h10019);
        look("R1", 20'h1001B); look("R1", 20'h10021);
        // R3: upper bits do not matter
        cyc("R3", 1, 3, 64'hABCD_0000_00F0_0001, 0, 0, 20'h00001);
        look("R3", 20'h00001);
        // R6: unlisted codes rejected
        cyc("R6", 1, 5, 64'h3, 0, 0, 20'h00003);
        cyc("R6", 1, 5, 64'h10_0000, 0, 0, 20'h00000);
        look("R6", 20'h00003); look("R6", 20'h00000);
        // R2: index boundaries
        cyc("R2", 1, 2, 64'h2, 0, 0, 20'h00002);
        cyc("R2", 1, 19, 64'h2, 0, 0, 20'h00002);
        cyc("R2", 1, 31, 64'h2, 0, 0, 20'h00002);
        look("R2", 20'h00002);
        cyc("R2", 1, 18, 64'h2, 0, 0, 20'h00002);
        look("R2", 20'h00002);
        cyc("R2", 1, 2, 64'h0, 0, 0, 20'h00002);
        look("R2", 20'h00002);
        // R4: first binding wins
        cyc("R4", 1, 7, 64'h1, 0, 0, 20'h00001);
        look("R4", 20'h00001);
        // R5: removal of every binding on a counter
        cyc("R5", 1, 3, 64'h10019, 0, 0, 20'h10019);
        look("R5", 20'h10019);
        cyc("R5", 1, 9, 64'h0, 0, 0, 20'h00001);
        look("R5", 20'h00001);
        cyc("R5", 1, 3, 64'h0, 0, 0, 20'h00001);
        look("R5", 20'h00001); look("R5", 20'h10019); look("R5", 20'h00002);
        // R7: split writes in 32-bit mode
        cyc("R7", 1, 4, 64'h0001_001B, 1, 0, 20'h1001B);
        look("R7", 20'h1001B);
        cyc("R7", 1, 4, 64'h0, 1, 1, 20'h1001B);
        look("R7", 20'h1001B);
        cyc("R7", 1, 4, 64'h0001_0021, 1, 0, 20'h10021);
        cyc("R7", 1, 4, 64'h5, 1, 1, 20'h10021);
        look("R7", 20'h10021);
        cyc("R7", 1, 4, 64'h0, 1, 0, 20'h10021);
        cyc("R7", 1, 4, 64'h8000_0000, 1, 1, 20'h10021);
        look("R7", 20'h10021); look("R7", 20'h1001B);
        cyc("R7", 1, 4, 64'h0, 1, 1, 20'h10021);
        look("R7", 20'h10021); look("R7", 20'h1001B);
        // R8: high half ignored in 64-bit mode
        cyc("R8", 1, 6, 64'h10019, 0, 1, 20'h10019);
        look("R8", 20'h10019);
        // R9: visibility timing and miss value
        cyc("R9", 1, 10, 64'h10019, 0, 0, 20'h10019);
        look("R9", 20'h10019);
        look("R9", 20'h12345);
        cyc("R9", 1, 10, 64'h0, 0, 0, 20'h10019);
        look("R9", 20'h10019);
        // R1: reset clears a populated table
        @(negedge clk); rst = 1'b1; wr_valid = 0;
        @(negedge clk); rst = 1'b0;
        look("R1", 20'h00002); look("R1", 20'h00001);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule